// File: doc/BRIEF.md
# Atomic Read-Modify-Write Memory Unit

This unit sits in front of a small synchronous word memory and serves several requesting processors. Each processor presents an operation code, a word address and up to two operand words. The unit runs the operation as one uninterruptible read-then-write sequence and returns the word that was in memory before the operation. It also returns a status bit that reports whether a compare-and-swap or a test-and-set took effect.

Requesters compete for the memory through a round-robin arbiter. A grant holds the memory for exactly two cycles. In the first cycle the word is read. In the second cycle the new value is written back, if there is one. No other requester can be granted while a sequence is in progress, so no other access can fall between the read and the write of any operation. Lock, semaphore and lock-free queue code built on these primitives can rely on that property.

Top module: `rmw_atomic_unit`

## Requirements
- R1: Op code 0 (load) returns the addressed word, leaves memory unchanged and returns status 1.
- R2: Op code 1 (store) writes operand A to the addressed word, returns the old word and returns status 1.
- R3: Op code 2 (test-and-set) returns the old word. It writes 1 to the location and returns status 1 only when the old word was 0. Otherwise it leaves memory unchanged and returns status 0.
- R4: Op code 3 (fetch-and-add) returns the old word, writes back the old word plus operand A modulo 2^DW, and returns status 1.
- R5: Op code 4 (swap) returns the old word, writes operand A to the location and returns status 1.
- R6: Op code 5 (compare-and-swap) returns the old word. When the old word equals operand A, it writes operand B and returns status 1. Otherwise memory is unchanged and the status is 0.
- R7: Op codes 6 and 7 behave as a load that reports status 0, and they never change memory.
- R8: The response is a single-cycle rsp_valid pulse, asserted exactly two clock cycles after the cycle in which the request was granted.
- R9: At most one grant is given per cycle, and no grant is given in the cycle that follows a grant. The read and the write of one operation are therefore never separated by another access.
- R10: The grant goes only to a port with req_valid set. The search starts at the port numbered one above the last granted port, counting upwards and wrapping around to port 0.
- R11: rsp_id carries the number of the port whose request produced the response.
- R12: After reset no response and no grant are pending, every memory word reads as 0, and port 0 has first priority.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NPORT | Per-port request present; held until granted |
| req_op | input | NPORT*3 | Per-port op code (0 load, 1 store, 2 test-and-set, 3 fetch-and-add, 4 swap, 5 compare-and-swap) |
| req_addr | input | NPORT*AW | Per-port word address |
| req_opa | input | NPORT*DW | Per-port operand A (store data, addend, swap value, compare value) |
| req_opb | input | NPORT*DW | Per-port operand B (compare-and-swap new value) |
| req_grant | output | NPORT | One-hot grant; the request is taken at the end of this cycle |
| rsp_valid | output | 1 | Response pulse |
| rsp_id | output | IDW | Port number of the answered request |
| rsp_data | output | DW | Memory word before the operation |
| rsp_ok | output | 1 | Operation status |

## Verification
Directed sequences cover each primitive on both sides of its condition. Test-and-set is tried on a zero word and on a word it has already set. Compare-and-swap is tried with a matching and with a stale expected value. Fetch-and-add carries past the top of the word. These cases tell apart conditional and unconditional write-back and show the wrap. A load after each one shows whether memory was touched.

Random traffic then sends all op codes from all ports to a few shared addresses at high request rates. The unit is compared against a reference memory model that is updated in grant order, so a lost or interleaved write, a wrong rotation of the arbiter, or a late or early response each shows up as a mismatch.

// File: rtl/rmw_pkg.sv
package rmw_pkg;

    localparam int OPW = 3;

    typedef enum logic [OPW-1:0] {
        OP_LOAD  = 3'd0,
        OP_STORE = 3'd1,
        OP_TAS   = 3'd2,
        OP_FADD  = 3'd3,
        OP_SWAP  = 3'd4,
        OP_CAS   = 3'd5,
        OP_RSV6  = 3'd6,
        OP_RSV7  = 3'd7
    } rmw_op_e;

    typedef enum logic {
        PH_IDLE  = 1'b0,
        PH_WRITE = 1'b1
    } rmw_phase_e;

endpackage

// File: rtl/rmw_rr_arb.sv
module rmw_rr_arb #(
    parameter int N   = 3,
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [N-1:0]   req,
    input  logic           advance,
    output logic           any,
    output logic [IDW-1:0] win,
    output logic [N-1:0]   onehot
);

    logic [IDW-1:0] last_d, last_q;

    always_comb begin
        int idx;
        any = 1'b0;
        win = '0;
        idx = 0;
        for (int k = 1; k <= N; k++) begin
            idx = int'(last_q) + k;
            if (idx >= N) idx = idx - N;
            if (!any && req[idx]) begin
                any = 1'b1;
                win = IDW'(idx);
            end
        end
        for (int i = 0; i < N; i++) begin
            onehot[i] = any && (win == IDW'(i));
        end
        last_d = advance ? win : last_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= IDW'(N - 1);
        else        last_q <= last_d;
    end

    AST_WIN_REQUESTED: assert property (@(posedge clk) disable iff (!rst_n)
        advance |-> req[win]); // R10

endmodule

// File: rtl/rmw_alu.sv
module rmw_alu
    import rmw_pkg::*;
#(
    parameter int DW = 16
) (
    input  rmw_op_e         op,
    input  logic [DW-1:0]   old_word,
    input  logic [DW-1:0]   opa,
    input  logic [DW-1:0]   opb,
    output logic            wr_en,
    output logic [DW-1:0]   wr_word,
    output logic            ok
);

    logic is_zero;
    logic is_match;

    always_comb begin
        is_zero  = (old_word == '0);
        is_match = (old_word == opa);
        wr_en    = 1'b0;
        wr_word  = old_word;
        ok       = 1'b1;
        unique case (op)
            OP_LOAD: begin
                wr_en = 1'b0;
            end
            OP_STORE: begin
                wr_en   = 1'b1;
                wr_word = opa;
            end
            OP_TAS: begin
                wr_en   = is_zero;
                wr_word = DW'(1);
                ok      = is_zero;
            end
            OP_FADD: begin
                wr_en   = 1'b1;
                wr_word = old_word + opa;
            end
            OP_SWAP: begin
                wr_en   = 1'b1;
                wr_word = opa;
            end
            OP_CAS: begin
                wr_en   = is_match;
                wr_word = opb;
                ok      = is_match;
            end
            default: begin
                wr_en = 1'b0;
                ok    = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rmw_ram.sv
module rmw_ram #(
    parameter int AW = 4,
    parameter int DW = 16,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_word,
    output logic [DW-1:0] rd_word
);

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] rd_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
            rd_q <= '0;
        end else begin
            if (wr_en) mem_q[wr_addr] <= wr_word;
            if (rd_en) rd_q <= mem_q[rd_addr];
        end
    end

    assign rd_word = rd_q;

    AST_NO_RD_WR_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && wr_en)); // R9

endmodule

// File: rtl/rmw_atomic_unit.sv
module rmw_atomic_unit
    import rmw_pkg::*;
#(
    parameter int NPORT = 3,
    parameter int AW    = 4,
    parameter int DW    = 16,
    localparam int IDW  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NPORT-1:0]     req_valid,
    input  logic [NPORT*OPW-1:0] req_op,
    input  logic [NPORT*AW-1:0]  req_addr,
    input  logic [NPORT*DW-1:0]  req_opa,
    input  logic [NPORT*DW-1:0]  req_opb,
    output logic [NPORT-1:0]     req_grant,
    output logic                 rsp_valid,
    output logic [IDW-1:0]       rsp_id,
    output logic [DW-1:0]        rsp_data,
    output logic                 rsp_ok
);

    typedef struct packed {
        rmw_phase_e    ph;
        rmw_op_e       op;
        logic [AW-1:0] addr;
        logic [DW-1:0] opa;
        logic [DW-1:0] opb;
        logic [IDW-1:0] id;
        logic          rsp_v;
        logic [IDW-1:0] rsp_id;
        logic [DW-1:0] rsp_d;
        logic          rsp_ok;
    } unit_st_t;

    unit_st_t st_d, st_q;

    logic             arb_any;
    logic [IDW-1:0]   arb_win;
    logic [NPORT-1:0] arb_onehot;
    logic             grant_en;

    logic [AW-1:0]    win_addr;
    logic [DW-1:0]    mem_word;
    logic             alu_we;
    logic [DW-1:0]    alu_word;
    logic             alu_ok;
    logic             ram_we;

    rmw_rr_arb #(
        .N   (NPORT),
        .IDW (IDW)
    ) u_arb (
        .clk     (clk),
        .rst_n   (rst_n),
        .req     (req_valid),
        .advance (grant_en),
        .any     (arb_any),
        .win     (arb_win),
        .onehot  (arb_onehot)
    );

    rmw_alu #(
        .DW (DW)
    ) u_alu (
        .op       (st_q.op),
        .old_word (mem_word),
        .opa      (st_q.opa),
        .opb      (st_q.opb),
        .wr_en    (alu_we),
        .wr_word  (alu_word),
        .ok       (alu_ok)
    );

    rmw_ram #(
        .AW (AW),
        .DW (DW)
    ) u_ram (
        .clk     (clk),
        .rst_n   (rst_n),
        .rd_en   (grant_en),
        .rd_addr (win_addr),
        .wr_en   (ram_we),
        .wr_addr (st_q.addr),
        .wr_word (alu_word),
        .rd_word (mem_word)
    );

    always_comb begin
        st_d     = st_q;
        st_d.rsp_v = 1'b0;
        grant_en = 1'b0;
        ram_we   = 1'b0;
        win_addr = req_addr[int'(arb_win)*AW +: AW];

        unique case (st_q.ph)
            PH_IDLE: begin
                if (arb_any) begin
                    grant_en  = 1'b1;
                    st_d.ph   = PH_WRITE;
                    st_d.op   = rmw_op_e'(req_op[int'(arb_win)*OPW +: OPW]);
                    st_d.addr = win_addr;
                    st_d.opa  = req_opa[int'(arb_win)*DW +: DW];
                    st_d.opb  = req_opb[int'(arb_win)*DW +: DW];
                    st_d.id   = arb_win;
                end
            end
            PH_WRITE: begin
                ram_we      = alu_we;
                st_d.ph     = PH_IDLE;
                st_d.rsp_v  = 1'b1;
                st_d.rsp_id = st_q.id;
                st_d.rsp_d  = mem_word;
                st_d.rsp_ok = alu_ok;
            end
            default: st_d.ph = PH_IDLE;
        endcase

        req_grant = grant_en ? arb_onehot : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rsp_valid = st_q.rsp_v;
    assign rsp_id    = st_q.rsp_id;
    assign rsp_data  = st_q.rsp_d;
    assign rsp_ok    = st_q.rsp_ok;

    AST_SINGLE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(req_grant)); // R9
    AST_LOCKOUT: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |=> (req_grant == '0)); // R9
    AST_GRANT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((req_grant & ~req_valid) == '0)); // R10
    AST_RSP_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |=> ##1 rsp_valid); // R8
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R8
    AST_RSP_ID: assert property (@(posedge clk) disable iff (!rst_n)
        (|req_grant) |=> ##1 (rsp_id == $past(arb_win, 2))); // R11

endmodule

// File: tb/rmw_atomic_unit_bench.sv
`timescale 1ns/1ps
module rmw_atomic_unit_bench;
    import rmw_pkg::*;

    localparam int NP  = 3;
    localparam int AW  = 4;
    localparam int DW  = 16;
    localparam int IDW = 2;
    localparam int WATCHDOG = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    // requester state (driver-owned)
    logic [NP-1:0] req_v;
    logic [2:0]    r_op   [NP];
    logic [AW-1:0] r_addr [NP];
    logic [DW-1:0] r_a    [NP];
    logic [DW-1:0] r_b    [NP];
    logic          r_has  [NP];
    logic [DW-1:0] r_expd [NP];
    logic          r_expok[NP];

    logic [NP*3-1:0]  f_op;
    logic [NP*AW-1:0] f_addr;
    logic [NP*DW-1:0] f_a, f_b;

    always_comb begin
        for (int i = 0; i < NP; i++) begin
            f_op[i*3 +: 3]    = r_op[i];
            f_addr[i*AW +: AW] = r_addr[i];
            f_a[i*DW +: DW]   = r_a[i];
            f_b[i*DW +: DW]   = r_b[i];
        end
    end

    logic [NP-1:0]  req_grant;
    logic           rsp_valid;
    logic [IDW-1:0] rsp_id;
    logic [DW-1:0]  rsp_data;
    logic           rsp_ok;

    rmw_atomic_unit #(.NPORT(NP), .AW(AW), .DW(DW)) u_rmw_atomic_unit (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_v),
        .req_op    (f_op),
        .req_addr  (f_addr),
        .req_opa   (f_a),
        .req_opb   (f_b),
        .req_grant (req_grant),
        .rsp_valid (rsp_valid),
        .rsp_id    (rsp_id),
        .rsp_data  (rsp_data),
        .rsp_ok    (rsp_ok)
    );

    // main-owned command mailbox
    int            cmd_seq = 0;
    int            c_port = 0;
    logic [2:0]    c_op = '0;
    logic [AW-1:0] c_addr = '0;
    logic [DW-1:0] c_a = '0, c_b = '0, c_expd = '0;
    logic          c_expok = 1'b0;
    logic          rand_en = 1'b0;
    logic          done_req = 1'b0;

    // driver-owned
    int cmd_taken = 0;

    // cycle counter
    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // monitor-owned
    int            pass_n = 0;
    int            fail_n = 0;
    logic [NP-1:0] seen_grant = '0;
    logic          pend = 1'b0;
    int            e_cyc = 0;
    int            e_id = 0;
    logic [2:0]    e_op = '0;
    logic [DW-1:0] e_data = '0;
    logic          e_ok = 1'b0;
    logic          e_has = 1'b0;
    logic [DW-1:0] e_dexp = '0;
    logic          e_dok = 1'b0;
    int            rr_last = NP - 1;
    logic          prev_g = 1'b0;
    logic          rst_seen = 1'b0;
    logic [DW-1:0] model [1 << AW];

    function automatic string op_tag(input logic [2:0] op);
        case (op)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R3";
            3'd3: return "R4";
            3'd4: return "R5";
            3'd5: return "R6";
            default: return "R7";
        endcase
    endfunction

    // reference behaviour of one operation, written from the requirements
    function automatic void ref_op(input logic [2:0] op, input logic [DW-1:0] old,
                                   input logic [DW-1:0] a, input logic [DW-1:0] b,
                                   output logic we, output logic [DW-1:0] nw,
                                   output logic ok);
        we = 1'b0; nw = old; ok = 1'b1;
        case (op)
            3'd0: ;
            3'd1: begin we = 1'b1; nw = a; end
            3'd2: begin ok = (old == 0); we = ok; nw = 1; end
            3'd3: begin we = 1'b1; nw = old + a; end
            3'd4: begin we = 1'b1; nw = a; end
            3'd5: begin ok = (old == a); we = ok; nw = b; end
            default: ok = 1'b0;
        endcase
    endfunction

    task automatic chk(input bit good, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        if (good) pass_n++;
        else begin
            fail_n++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", pass_n, pass_n + fail_n);
        $finish;
    endtask

    // monitor: samples away from the rising edge
    always @(negedge clk) begin
        if (!rst_n) begin
            pend = 1'b0;
            rr_last = NP - 1;
            prev_g = 1'b0;
            seen_grant = '0;
            for (int i = 0; i < (1 << AW); i++) model[i] = '0;
        end else begin
            if (!rst_seen) begin
                rst_seen = 1'b1;
                chk(!rsp_valid && (req_grant == 0), "R12", "idle after reset",
                    {rsp_valid, 28'd0, req_grant}, 0);
            end
            // response side
            if (rsp_valid) begin
                if (!pend) begin
                    chk(1'b0, "R8", "unexpected response", 1, 0);
                end else begin
                    chk(cyc == e_cyc, "R8", "response cycle", cyc, e_cyc);
                    chk(rsp_data == e_data, op_tag(e_op), "old word", rsp_data, e_data);
                    chk(rsp_ok == e_ok, op_tag(e_op), "status", rsp_ok, e_ok);
                    chk(int'(rsp_id) == e_id, "R11", "response id", rsp_id, e_id);
                    if (e_has) begin
                        chk(rsp_data == e_dexp && rsp_ok == e_dok, op_tag(e_op),
                            "directed value", {rsp_ok, 15'd0, rsp_data}, {e_dok, 15'd0, e_dexp});
                    end
                    pend = 1'b0;
                end
            end else if (pend && cyc > e_cyc) begin
                chk(1'b0, "R8", "missing response", cyc, e_cyc);
                pend = 1'b0;
            end
            // grant side
            if (req_grant != 0) begin
                int g;
                int want;
                logic we;
                logic [DW-1:0] nw;
                logic ok;
                g = 0;
                for (int i = NP - 1; i >= 0; i--) if (req_grant[i]) g = i;
                chk($countones(req_grant) == 1, "R9", "grant one-hot", req_grant, 1);
                chk(!prev_g, "R9", "grant in cycle after grant", 1, 0);
                want = -1;
                for (int k = 1; k <= NP; k++) begin
                    int idx;
                    idx = (rr_last + k) % NP;
                    if (want < 0 && req_v[idx]) want = idx;
                end
                chk(g == want, "R10", "round-robin winner", g, want);
                rr_last = g;
                ref_op(r_op[g], model[r_addr[g]], r_a[g], r_b[g], we, nw, ok);
                e_data = model[r_addr[g]];
                e_ok = ok;
                if (we) model[r_addr[g]] = nw;
                e_op = r_op[g];
                e_id = g;
                e_cyc = cyc + 2;
                e_has = r_has[g];
                e_dexp = r_expd[g];
                e_dok = r_expok[g];
                pend = 1'b1;
            end
            prev_g = (req_grant != 0);
            seen_grant = req_grant;
            if (cyc > WATCHDOG) begin
                chk(1'b0, "R8", "watchdog expired", cyc, WATCHDOG);
                finish_run();
            end
            if (done_req) finish_run();
        end
    end

    // driver: changes inputs just after the rising edge
    always @(posedge clk) begin
        #1;
        if (!rst_n) begin
            req_v = '0;
            for (int i = 0; i < NP; i++) begin
                r_op[i] = '0; r_addr[i] = '0; r_a[i] = '0; r_b[i] = '0;
                r_has[i] = 1'b0; r_expd[i] = '0; r_expok[i] = 1'b0;
            end
        end else begin
            for (int i = 0; i < NP; i++) if (req_v[i] && seen_grant[i]) req_v[i] = 1'b0;
            if (cmd_taken != cmd_seq && !req_v[c_port]) begin
                r_op[c_port] = c_op; r_addr[c_port] = c_addr;
                r_a[c_port] = c_a; r_b[c_port] = c_b;
                r_has[c_port] = 1'b1; r_expd[c_port] = c_expd; r_expok[c_port] = c_expok;
                req_v[c_port] = 1'b1;
                cmd_taken = cmd_seq;
            end
            if (rand_en) begin
                for (int i = 0; i < NP; i++) begin
                    if (!req_v[i] && ($urandom_range(0, 3) != 0)) begin
                        r_op[i] = 3'($urandom_range(0, 7));
                        r_addr[i] = AW'($urandom_range(0, 3));
                        r_a[i] = ($urandom_range(0, 3) == 0) ? DW'($urandom) : DW'($urandom_range(0, 2));
                        r_b[i] = ($urandom_range(0, 3) == 0) ? DW'($urandom) : DW'($urandom_range(0, 2));
                        r_has[i] = 1'b0;
                        req_v[i] = 1'b1;
                    end
                end
            end
        end
    end

    task automatic wait_quiet();
        do @(posedge clk);
        while (cmd_taken != cmd_seq || req_v != 0 || pend);
        @(posedge clk);
    endtask

    task automatic dir(input int p, input logic [2:0] op, input logic [AW-1:0] ad,
                       input logic [DW-1:0] a, input logic [DW-1:0] b,
                       input logic [DW-1:0] xd, input logic xok);
        @(posedge clk);
        c_port = p; c_op = op; c_addr = ad; c_a = a; c_b = b;
        c_expd = xd; c_expok = xok;
        cmd_seq = cmd_seq + 1;
        wait_quiet();
    endtask

    initial begin
        void'($urandom(32'd20240611));
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        dir(0, 3'd0, 4'd3, 16'h0, 16'h0, 16'h0000, 1'b1);    // R12 memory clear, R1
        dir(1, 3'd2, 4'd3, 16'h0, 16'h0, 16'h0000, 1'b1);    // R3 acquire
        dir(2, 3'd2, 4'd3, 16'h0, 16'h0, 16'h0001, 1'b0);    // R3 already held
        dir(0, 3'd0, 4'd3, 16'h0, 16'h0, 16'h0001, 1'b1);    // R3 held value is 1
        dir(1, 3'd1, 4'd5, 16'h0002, 16'h0, 16'h0000, 1'b1); // R2
        dir(2, 3'd3, 4'd5, 16'hFFFF, 16'h0, 16'h0002, 1'b1); // R4 wraps
        dir(0, 3'd0, 4'd5, 16'h0, 16'h0, 16'h0001, 1'b1);    // R4 result 1
        dir(1, 3'd4, 4'd6, 16'hABCD, 16'h0, 16'h0000, 1'b1); // R5
        dir(2, 3'd5, 4'd6, 16'hABCD, 16'h1234, 16'hABCD, 1'b1); // R6 match
        dir(0, 3'd5, 4'd6, 16'hABCD, 16'h5555, 16'h1234, 1'b0); // R6 stale
        dir(1, 3'd0, 4'd6, 16'h0, 16'h0, 16'h1234, 1'b1);    // R6 unchanged
        dir(2, 3'd6, 4'd6, 16'h7777, 16'h7777, 16'h1234, 1'b0); // R7
        dir(1, 3'd7, 4'd6, 16'h9999, 16'h9999, 16'h1234, 1'b0); // R7
        dir(0, 3'd0, 4'd6, 16'h0, 16'h0, 16'h1234, 1'b1);    // R7 no write
        @(posedge clk);
        rand_en = 1'b1;
        repeat (4000) @(posedge clk);
        rand_en = 1'b0;
        wait_quiet();
        done_req = 1'b1;
    end

endmodule